// File: doc/BRIEF.md
# Hot-Plug Slot Control Register Block

This block holds the slot-side registers and event logic of a downstream port that supports hot insertion and removal of an add-in card. Software reaches three registers through a simple single-cycle read/write port: a read-only 32-bit capability word, a 16-bit control word and a 16-bit status word. Four physical slot signals (attention button, power fault, retention latch sensor, card presence) are synchronised, edge-detected and latched as sticky event flags. Software clears them by writing ones.

The control word drives the slot power enable and two indicators, attention and power. Each indicator takes a two-bit on/blink/off code. The blinking output comes from a free-running prescaler with equal high and low time. Every write to the control word is acknowledged by a command-completed event a fixed number of cycles later. A single level interrupt is raised when the master enable is set and a pending event has its own enable set.

The register port is plain control: a write strobe, a select, write data, and read data that follows the select combinationally. There is no handshake and no back-pressure, so every strobe is accepted in the cycle it is seen.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, the control word reads 0x07C0 (both indicators off, power bit 1), the status word reads 0, and irq, slot_pwr_en, attn_drv and pwr_drv are all 0.
- R2: Select 0 reads the capability word. Bits 31:19 hold SLOT_NUM, bit 6 is 1 (hot-plug capable), bits 4:0 hold CAP_FLAGS, and all other bits are 0. Writes to select 0 change nothing.
- R3: Control bit 10 is the power controller. A value of 0 drives slot_pwr_en to 1, and a value of 1 drives it to 0. The output follows in the cycle after the write.
- R4: Control bits 7:6 set the attention indicator and bits 9:8 set the power indicator. Code 01 drives the output steadily high, 10 makes it blink, and 11 or the reserved code 00 drive it low.
- R5: A blinking indicator alternates between high and low phases, each exactly BLINK_HALF cycles long.
- R6: Status bit 0 (button) and bit 1 (power fault) latch on a rising input. Bit 2 (latch sensor) and bit 3 (presence) latch on either edge. A flag appears 3 cycles after the input changes and then stays set until it is cleared. Bit 5 shows the synchronised latch-sensor level and bit 6 shows the synchronised presence level, both 2 cycles after the input changes. Button release and fault removal latch nothing.
- R7: Writing status with a 1 in any of bits 4:0 clears that flag. A 0 leaves the flag unchanged. Writes to bits 6:5 have no effect.
- R8: Every control write sets status bit 4 (command completed) exactly CMD_DELAY cycles after the write edge. A second write before that point restarts the count.
- R9: irq is 1 exactly when control bit 5 is 1 and some status bit i in 4:0 is set together with control bit i. Bit 4 gates the command-completed event.
- R10: Control bits 15:11 and status bits 15:7 read as 0 whatever is written to them. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe for the selected register |
| acc_sel | input | 2 | Register select: 0 capability, 1 control, 2 status, 3 none |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 32 | Read data of the selected register |
| btn_in | input | 1 | Attention button, active high |
| pfault_in | input | 1 | Power fault detect, active high |
| mrl_in | input | 1 | Retention latch sensor level |
| prsnt_in | input | 1 | Card presence level |
| slot_pwr_en | output | 1 | Slot power enable |
| attn_drv | output | 1 | Attention indicator drive |
| pwr_drv | output | 1 | Power indicator drive |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or mis-set event flag shows at the status read in the first cycle after the write or edge that should have changed it. Through irq it shows as soon as the master and per-event enables select that flag. A command timer that loads or counts wrongly moves the command-completed flag off its expected edge, so the bench samples that flag one cycle before and one cycle at the expected edge. A wrong blink prescaler shows within one blink period as a run length other than BLINK_HALF on the indicator pin.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;
  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_code_e;

  typedef enum logic [1:0] {
    SEL_CAP  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int EVT_W      = 5;
  localparam int EV_BTN     = 0;
  localparam int EV_PF      = 1;
  localparam int EV_MRL     = 2;
  localparam int EV_PRS     = 3;
  localparam int EV_CC      = 4;
  localparam int CTL_W      = 11;
  localparam int CTL_MASTER = 5;
  localparam int CTL_ATTN   = 6;
  localparam int CTL_PIND   = 8;
  localparam int CTL_POWER  = 10;
  localparam int N_PINS     = 4;
  localparam logic [CTL_W-1:0] CTL_RESET = 11'h7C0;
endpackage

// File: rtl/hp_in_sync.sv
`timescale 1ns/1ps
module hp_in_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] level,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level[i] = sync_q;
    assign prev[i]  = prev_q;
  end
endmodule

// File: rtl/hp_blink.sv
`timescale 1ns/1ps
module hp_blink #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign phase = phase_q;

  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(phase_q));
endmodule

// File: rtl/hp_indicator.sv
`timescale 1ns/1ps
module hp_indicator
  import hp_slot_pkg::*;
(
  input  logic [1:0] code,
  input  logic       phase,
  output logic       drive
);
  always_comb begin
    unique case (ind_code_e'(code))
      IND_ON:    drive = 1'b1;
      IND_BLINK: drive = phase;
      default:   drive = 1'b0;
    endcase
  end
endmodule

// File: rtl/hp_cmd_timer.sv
`timescale 1ns/1ps
module hp_cmd_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= CW'(DELAY);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end
  assign done = (cnt_q == CW'(1)) && !start;

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DELAY));
endmodule

// File: rtl/hp_slot_regs.sv
`timescale 1ns/1ps
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter logic [12:0] SLOT_NUM   = 13'd1,
  parameter logic [4:0]  CAP_FLAGS  = 5'h1F,
  parameter int          CMD_DELAY  = 16,
  parameter int          BLINK_HALF = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic [1:0]  acc_sel,
  input  logic [15:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic        btn_in,
  input  logic        pfault_in,
  input  logic        mrl_in,
  input  logic        prsnt_in,
  output logic        slot_pwr_en,
  output logic        attn_drv,
  output logic        pwr_drv,
  output logic        irq
);
  localparam logic [31:0] CAP_WORD = {SLOT_NUM, 19'd0} | 32'h40 | {27'd0, CAP_FLAGS};

  logic [N_PINS-1:0] lvl, prv;
  logic [EVT_W-1:0]  evt_set, flags_q, clr_mask;
  logic [CTL_W-1:0]  ctrl_q;
  logic              ctrl_wr, stat_wr, cc_done, blink_ph;
  logic              btn_rise, pf_rise, mrl_chg, prs_chg;
  logic              unused_hi;

  assign unused_hi = &{1'b0, acc_wdata[15:CTL_W]};

  hp_in_sync #(.N(N_PINS)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({prsnt_in, mrl_in, pfault_in, btn_in}),
    .level(lvl), .prev(prv)
  );

  assign btn_rise = lvl[0] & ~prv[0];
  assign pf_rise  = lvl[1] & ~prv[1];
  assign mrl_chg  = lvl[2] ^ prv[2];
  assign prs_chg  = lvl[3] ^ prv[3];

  assign ctrl_wr = acc_wr && (acc_sel == SEL_CTRL);
  assign stat_wr = acc_wr && (acc_sel == SEL_STAT);

  hp_cmd_timer #(.DELAY(CMD_DELAY)) i_cmd (
    .clk(clk), .rst_n(rst_n), .start(ctrl_wr), .done(cc_done)
  );

  always_comb begin
    evt_set         = '0;
    evt_set[EV_BTN] = btn_rise;
    evt_set[EV_PF]  = pf_rise;
    evt_set[EV_MRL] = mrl_chg;
    evt_set[EV_PRS] = prs_chg;
    evt_set[EV_CC]  = cc_done;
    clr_mask        = stat_wr ? acc_wdata[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTL_RESET;
      flags_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= acc_wdata[CTL_W-1:0];
      flags_q <= (flags_q & ~clr_mask) | evt_set;
    end
  end

  hp_blink #(.HALF(BLINK_HALF)) i_blink (
    .clk(clk), .rst_n(rst_n), .phase(blink_ph)
  );

  hp_indicator i_attn (
    .code(ctrl_q[CTL_ATTN+1:CTL_ATTN]), .phase(blink_ph), .drive(attn_drv)
  );
  hp_indicator i_pind (
    .code(ctrl_q[CTL_PIND+1:CTL_PIND]), .phase(blink_ph), .drive(pwr_drv)
  );

  assign slot_pwr_en = ~ctrl_q[CTL_POWER];
  assign irq = ctrl_q[CTL_MASTER] & |(flags_q & ctrl_q[EVT_W-1:0]);

  always_comb begin
    unique case (reg_sel_e'(acc_sel))
      SEL_CAP:  acc_rdata = CAP_WORD;
      SEL_CTRL: acc_rdata = {{(32-CTL_W){1'b0}}, ctrl_q};
      SEL_STAT: acc_rdata = {25'd0, lvl[3], lvl[2], flags_q};
      default:  acc_rdata = '0;
    endcase
  end

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((flags_q & $past(acc_wdata[EVT_W-1:0] & ~evt_set)) == '0));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r6_btn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> !btn_rise);
  a_r8_cc_land: assert property (@(posedge clk) disable iff (!rst_n)
    cc_done |=> flags_q[EV_CC]);
  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTL_MASTER] |-> !irq);
endmodule

// File: tb/test_hp_slot_regs.sv
`timescale 1ns/1ps
module test_hp_slot_regs;
  localparam int HALF  = 8;
  localparam int DLY   = 16;
  localparam logic [12:0] SN = 13'h155;
  localparam logic [4:0]  CF = 5'b10110;

  logic clk = 1'b0, rst_n = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [15:0] acc_wdata = 16'd0;
  logic [31:0] acc_rdata;
  logic btn_in = 1'b0, pfault_in = 1'b0, mrl_in = 1'b0, prsnt_in = 1'b0;
  logic slot_pwr_en, attn_drv, pwr_drv, irq;

  always #10 clk = ~clk;

  hp_slot_regs #(.SLOT_NUM(SN), .CAP_FLAGS(CF), .CMD_DELAY(DLY), .BLINK_HALF(HALF)) i_hp_slot_regs (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .btn_in(btn_in), .pfault_in(pfault_in), .mrl_in(mrl_in),
    .prsnt_in(prsnt_in), .slot_pwr_en(slot_pwr_en), .attn_drv(attn_drv),
    .pwr_drv(pwr_drv), .irq(irq)
  );

  typedef struct { string req; int what; logic [31:0] exp; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.what)
        0: act = acc_rdata;
        1: act = {31'd0, irq};
        2: act = {31'd0, slot_pwr_en};
        3: act = {31'd0, attn_drv};
        default: act = {31'd0, pwr_drv};
      endcase
      check(it.req, act, it.exp);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    acc_sel = sel; acc_wdata = d; acc_wr = 1'b1;
    @(posedge clk); #1;
    acc_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] sel, logic [31:0] e);
    acc_sel = sel;
    sb.push_back('{req, 0, e});
    @(negedge clk); #1;
  endtask

  task automatic pin(string req, int what, logic e);
    sb.push_back('{req, what, {31'd0, e}});
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd("R1", 2'd1, 32'h7C0);
    rd("R1", 2'd2, 32'h0);
    pin("R1", 1, 1'b0);
    pin("R1", 2, 1'b0);
    pin("R1", 3, 1'b0);
    pin("R1", 4, 1'b0);
    // R2 capability word, write ignored
    rd("R2", 2'd0, {SN, 19'd0} | 32'h40 | {27'd0, CF});
    wr(2'd0, 16'hFFFF);
    rd("R2", 2'd0, {SN, 19'd0} | 32'h40 | {27'd0, CF});
    rd("R10", 2'd3, 32'h0);
    // R3/R4/R10 control write with reserved bits
    wr(2'd1, 16'hF940);
    rd("R10", 2'd1, 32'h140);
    pin("R3", 2, 1'b1);
    pin("R4", 3, 1'b1);
    pin("R4", 4, 1'b1);
    tick(DLY);
    rd("R8", 2'd2, 32'h10);
    // R7 write-one-to-clear
    wr(2'd2, 16'h0000);
    rd("R7", 2'd2, 32'h10);
    wr(2'd2, 16'h0060);
    rd("R7", 2'd2, 32'h10);
    wr(2'd2, 16'h0010);
    rd("R7", 2'd2, 32'h0);
    // R8 exact delay
    wr(2'd1, 16'h0140);
    tick(DLY - 1);
    rd("R8", 2'd2, 32'h0);
    tick(1);
    rd("R8", 2'd2, 32'h10);
    wr(2'd2, 16'h0010);
    // R8 restart on second write
    wr(2'd1, 16'h0140);
    tick(10);
    wr(2'd1, 16'h0140);
    tick(DLY - 1);
    rd("R8", 2'd2, 32'h0);
    tick(1);
    rd("R8", 2'd2, 32'h10);
    wr(2'd2, 16'h001F);
    // R6 presence rise
    prsnt_in = 1'b1;
    tick(2);
    rd("R6", 2'd2, 32'h40);
    tick(1);
    rd("R6", 2'd2, 32'h48);
    wr(2'd2, 16'h0008);
    // R6 presence fall
    prsnt_in = 1'b0;
    tick(2);
    rd("R6", 2'd2, 32'h00);
    tick(1);
    rd("R6", 2'd2, 32'h08);
    wr(2'd2, 16'h0008);
    // R6 latch sensor
    mrl_in = 1'b1;
    tick(3);
    rd("R6", 2'd2, 32'h24);
    wr(2'd2, 16'h0004);
    rd("R7", 2'd2, 32'h20);
    // R6 button press and release
    btn_in = 1'b1;
    tick(3);
    rd("R6", 2'd2, 32'h21);
    wr(2'd2, 16'h0001);
    btn_in = 1'b0;
    tick(5);
    rd("R6", 2'd2, 32'h20);
    // R6 power fault
    pfault_in = 1'b1;
    tick(3);
    rd("R6", 2'd2, 32'h22);
    wr(2'd2, 16'h001F);
    pfault_in = 1'b0;
    tick(5);
    rd("R6", 2'd2, 32'h20);
    // R9 interrupt gating
    wr(2'd1, 16'h0161);
    pin("R9", 1, 1'b0);
    tick(DLY);
    rd("R9", 2'd2, 32'h30);
    pin("R9", 1, 1'b0);
    btn_in = 1'b1;
    tick(3);
    pin("R9", 1, 1'b1);
    btn_in = 1'b0;
    wr(2'd2, 16'h0001);
    pin("R9", 1, 1'b0);
    wr(2'd1, 16'h015F);
    pin("R9", 1, 1'b0);
    wr(2'd1, 16'h017F);
    pin("R9", 1, 1'b1);
    wr(2'd2, 16'h001F);
    pin("R9", 1, 1'b0);
    tick(DLY + 4);
    pin("R9", 1, 1'b1);
    // R3 power off, R4 reserved code
    wr(2'd1, 16'h0540);
    pin("R3", 2, 1'b0);
    wr(2'd1, 16'h0000);
    pin("R3", 2, 1'b1);
    pin("R4", 3, 1'b0);
    pin("R4", 4, 1'b0);
    // R5 blink on power indicator, attention off
    wr(2'd1, 16'h02C0);
    tick(1);
    begin
      int run = 0;
      int runs_seen = 0;
      bit started = 1'b0;
      bit attn_seen = 1'b0;
      logic last = 1'bx;
      for (int k = 0; k < 6 * HALF; k++) begin
        @(negedge clk);
        if (attn_drv) attn_seen = 1'b1;
        if (k == 0) begin
          last = pwr_drv; run = 1;
        end else if (pwr_drv == last) begin
          run++;
        end else begin
          if (started) begin
            check("R5", run, HALF);
            runs_seen++;
          end
          started = 1'b1;
          last = pwr_drv; run = 1;
        end
      end
      check("R5", (runs_seen >= 3) ? 1 : 0, 1);
      check("R4", {31'd0, attn_seen}, 32'd0);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule